// File: doc/BRIEF.md
# Dual-Code Master-Slave Up Counter

This block is an N-bit counter organised as two register ranks that follow the master and slave halves of a chain of toggle stages. The slave rank is read as a plain binary count. The master rank is read as the reflected Gray code of that same count, so exactly one master bit changes on each step. Complemented copies of both ranks are also provided as outputs. As the counter advances, these complemented outputs run downward.

Counting needs two enable inputs, and both must be high at the same time. A load input presets both ranks from two data buses. The relation between the buses chooses how the first bus is read. If the second bus is the bitwise complement of the first, the first bus is taken as a Gray value. In every other case it is taken as a binary value. Everything runs on a single clock with a synchronous reset.

Top module: `ms_dual_counter`

## Requirements
- R1: While reset is high at a rising clock edge, both ranks are cleared to 0. This has priority over load and counting.
- R2: Without load, the counter holds its value unless both enables are high.
- R3: With both enables high and no load, the binary output increments by one per clock edge. It wraps from all ones to zero.
- R4: The Gray output always equals bin_q XOR (bin_q >> 1).
- R5: Each count step, including the wrap, changes exactly one Gray output bit.
- R6: bin_dn is the complement of bin_q and gray_dn is the complement of gray_q, so bin_dn decreases by one for each count step.
- R7: A load with pre_b equal to pre_a puts pre_a on bin_q, with its Gray form on gray_q.
- R8: A load with pre_b equal to ~pre_a puts pre_a on gray_q, with its binary decoding on bin_q.
- R9: A load in which pre_b is neither equal nor complementary to pre_a is treated as a binary preset of pre_a, and pre_b has no effect.
- R10: Load takes priority over counting when both happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_a | input | 1 | First count enable |
| en_b | input | 1 | Second count enable |
| load | input | 1 | Preset strobe |
| pre_a | input | N | Preset value |
| pre_b | input | N | Code-select companion bus |
| bin_q | output | N | Slave rank, binary count |
| gray_q | output | N | Master rank, Gray count |
| bin_dn | output | N | Complement of bin_q |
| gray_dn | output | N | Complement of gray_q |

## Verification
The embedded properties check the same things on every clock edge. They check that the Gray rank matches the encoding of the binary rank and that a count step changes exactly one Gray bit. They also check that the binary rank increments or holds as the enables demand, and that reset and load put the expected values on the ranks. Some cases can only be shown by the bench's sweeps: the decoding of every Gray preset, the fallback to a binary preset for mixed bus relations, the complemented outputs over a full wrap, and load taking priority over counting. The bench runs these sweeps over a 4-bit instance.

// File: rtl/ms_dual_counter.sv
module ms_dual_counter #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_a,
  input  logic         en_b,
  input  logic         load,
  input  logic [N-1:0] pre_a,
  input  logic [N-1:0] pre_b,
  output logic [N-1:0] bin_q,
  output logic [N-1:0] gray_q,
  output logic [N-1:0] bin_dn,
  output logic [N-1:0] gray_dn
);

  function automatic logic [N-1:0] gray_step(input logic [N-1:0] g);
    logic [N-1:0] r;
    logic hit;
    r = g;
    hit = 1'b0;
    if (!(^g)) r[0] = ~g[0];
    else begin
      for (int i = 0; i < N-1; i++)
        if (!hit && g[i]) begin
          r[i+1] = ~g[i+1];
          hit = 1'b1;
        end
      if (!hit) r[N-1] = ~g[N-1];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] gray_to_bin(input logic [N-1:0] g);
    logic [N-1:0] b;
    b[N-1] = g[N-1];
    for (int i = N-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [N-1:0] master_r, slave_r;
  logic         run, gray_pre;

  assign run      = en_a & en_b;
  assign gray_pre = (pre_b == ~pre_a);

  always_ff @(posedge clk) begin
    if (rst) begin
      master_r <= '0;
      slave_r  <= '0;
    end else if (load) begin
      if (gray_pre) begin
        master_r <= pre_a;
        slave_r  <= gray_to_bin(pre_a);
      end else begin
        master_r <= pre_a ^ (pre_a >> 1);
        slave_r  <= pre_a;
      end
    end else if (run) begin
      master_r <= gray_step(master_r);
      slave_r  <= slave_r + 1'b1;
    end
  end

  assign bin_q   = slave_r;
  assign gray_q  = master_r;
  assign bin_dn  = ~slave_r;
  assign gray_dn = ~master_r;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (bin_q == '0) && (gray_q == '0));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!load && !run) |=> $stable(bin_q) && $stable(gray_q));

  a_r3_binary_step: assert property (@(posedge clk) disable iff (rst)
    (!load && run) |=> bin_q == $past(bin_q) + 1'b1);

  a_r4_gray_matches: assert property (@(posedge clk) disable iff (rst)
    gray_q == (bin_q ^ (bin_q >> 1)));

  a_r5_single_bit: assert property (@(posedge clk) disable iff (rst)
    (!load && run) |=> $countones(gray_q ^ $past(gray_q)) == 1);

  a_r7_binary_preset: assert property (@(posedge clk) disable iff (rst)
    (load && pre_b == pre_a) |=> bin_q == $past(pre_a));

  a_r8_gray_preset: assert property (@(posedge clk) disable iff (rst)
    (load && pre_b == ~pre_a) |=> gray_q == $past(pre_a));

endmodule

// File: tb/test_ms_dual_counter.sv
module test_ms_dual_counter;
  localparam int N = 4;
  localparam int M = 1 << N;

  logic         clk = 0;
  logic         rst = 1;
  logic         en_a = 0, en_b = 0, load = 0;
  logic [N-1:0] pre_a = '0, pre_b = '0;
  logic [N-1:0] bin_q, gray_q, bin_dn, gray_dn;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ms_dual_counter #(.N(N)) i_ms_dual_counter (
    .clk(clk), .rst(rst), .en_a(en_a), .en_b(en_b), .load(load),
    .pre_a(pre_a), .pre_b(pre_b), .bin_q(bin_q), .gray_q(gray_q),
    .bin_dn(bin_dn), .gray_dn(gray_dn)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int enc(input int b);
    return (b ^ (b >> 1)) % M;
  endfunction

  function automatic int dec(input int g);
    int b = 0;
    for (int s = g; s != 0; s = s >> 1) b = b ^ s;
    return b % M;
  endfunction

  function automatic int ones(input int v);
    int c = 0;
    for (int i = 0; i < N; i++) c += (v >> i) & 1;
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int exp_b;
    int prev_g;
    @(negedge clk);
    tick();
    check("R1 bin", bin_q, 0);
    check("R1 gray", gray_q, 0);
    rst = 0;

    // R2: every combination other than both enables high holds the value
    for (int c = 0; c < 3; c++) begin
      en_a = c[0];
      en_b = c[1];
      tick();
      check("R2 hold bin", bin_q, 0);
      check("R2 hold gray", gray_q, 0);
    end

    // R3 R4 R5 R6: run through more than one full wrap
    en_a = 1;
    en_b = 1;
    exp_b = 0;
    for (int k = 0; k < M + 3; k++) begin
      prev_g = gray_q;
      tick();
      exp_b = (exp_b + 1) % M;
      check("R3 bin", bin_q, exp_b);
      check("R4 gray", gray_q, enc(exp_b));
      check("R5 bits changed", ones(prev_g ^ gray_q), 1);
      check("R6 bin_dn", bin_dn, M - 1 - exp_b);
      check("R6 gray_dn", gray_dn, (M - 1) ^ enc(exp_b));
    end

    // R7 R10: binary presets while both enables stay high
    load = 1;
    for (int v = 0; v < M; v++) begin
      pre_a = v[N-1:0];
      pre_b = v[N-1:0];
      tick();
      check("R7 R10 bin", bin_q, v);
      check("R7 gray", gray_q, enc(v));
    end

    // R8: Gray presets
    for (int g = 0; g < M; g++) begin
      pre_a = g[N-1:0];
      pre_b = ~g[N-1:0];
      tick();
      check("R8 gray", gray_q, g);
      check("R8 bin", bin_q, dec(g));
    end

    // R9: mixed relation falls back to a binary preset
    for (int v = 0; v < M; v++) begin
      pre_a = v[N-1:0];
      pre_b = v[N-1:0] ^ 4'b0101;
      tick();
      check("R9 bin", bin_q, v);
      check("R9 gray", gray_q, enc(v));
    end

    // R2: load dropped, enables split, value held after preset
    load = 0;
    en_b = 0;
    tick();
    check("R2 hold after load", bin_q, M - 1);

    // R1: reset wins over load and count
    en_b = 1;
    load = 1;
    rst = 1;
    pre_a = 4'd9;
    pre_b = 4'd9;
    tick();
    check("R1 priority bin", bin_q, 0);
    check("R1 priority gray", gray_q, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule